// File: doc/BRIEF.md
# Hashed Flow Cache with Chained Buckets

This block keeps the classification result of recently seen packet flows so that repeated packets of the same flow skip the slow rule search. A request carries a 104-bit flow key. The block hashes the key with a CRC to select a bucket. It then follows that bucket's singly linked chain of entries and compares the full key at each node. On a hit it returns the stored 8-bit class.

On a miss it asks an external classifier for the class and holds the request until the answer arrives. It then links the new flow at the head of the bucket's chain and returns the class. Entry slots are recycled strictly in order of arrival. When the pool is full, the oldest flow is first unlinked from its own chain.

A per-bucket lock bit in the top bit of each bucket word is set while a bucket is being searched or modified. A flush pulse empties the whole cache by sweeping every bucket. The same sweep runs after reset.

Top module: `flow_cache`

## Requirements
- R1: The bucket index is the low HW bits of a CRC-16 computed over the 104-bit key. The CRC uses polynomial 0x1021 and initial value 0xFFFF, with no final inversion, and takes key bit 103 first. The key is packed as {destination IP[31:0], source IP[31:0], destination port[15:0], source port[15:0], protocol[7:0]}.
- R2: A lookup of a cached key returns rsp_hit=1 with the class stored for it. rsp_valid rises on the (3+k)th falling clock edge after the accepting rising edge, where k is the number of cached flows in the same bucket that were inserted after it.
- R3: A lookup of an uncached key raises cls_req_valid with cls_req_key equal to the request key and holds both until cls_rsp_valid is seen. It then caches the flow and returns rsp_hit=0 with cls_rsp_class.
- R4: rsp_valid is a one-cycle pulse. req_ready stays low from the accepting edge until after the response.
- R5: At most NENT flows are cached. When a new flow arrives and the pool is full, the flow inserted earliest is dropped. A later lookup of the dropped flow misses. Hits do not change the replacement order, and all other flows, including those in the dropped flow's bucket, still hit.
- R6: A flush taken in the idle state holds req_ready low for exactly 2^HW cycles. After the flush, every key misses.
- R7: A flush has priority over a request presented in the same cycle, and that request is not accepted. A flush that arrives during a lookup is held until the lookup's response, then runs, holding req_ready low for 2^HW+1 cycles after the response cycle.
- R8: While reset is asserted, req_ready, rsp_valid and cls_req_valid are low. After reset, req_ready stays low for 2^HW cycles, and the cache is then empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pulse that empties the cache |
| req_valid | input | 1 | Lookup request present |
| req_key | input | 104 | Flow key |
| req_ready | output | 1 | Request accepted on this edge if req_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_class | output | 8 | Classification result |
| cls_req_valid | output | 1 | Request to the external classifier |
| cls_req_key | output | 104 | Key sent to the classifier |
| cls_rsp_valid | input | 1 | Classifier answer present |
| cls_rsp_class | input | 8 | Classifier answer |

## Verification
Two functions can collide in one cycle. A flush can meet a lookup request, or it can arrive while a lookup is waiting on the classifier. The bench drives flush and req_valid on the same edge and requires that the sweep runs, that no response appears, and that the offered key later misses. It also pulses flush in the middle of a miss and requires that the answer arrives intact, that req_ready stays low for one cycle plus the full sweep, and that the just-inserted flow is gone afterwards.

// File: rtl/flow_cache.sv
module flow_cache #(
  parameter int HW   = 8,
  parameter int NENT = 256,
  parameter int PW   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         req_valid,
  input  logic [103:0] req_key,
  output logic         req_ready,
  output logic         rsp_valid,
  output logic         rsp_hit,
  output logic [7:0]   rsp_class,
  output logic         cls_req_valid,
  output logic [103:0] cls_req_key,
  input  logic         cls_rsp_valid,
  input  logic [7:0]   cls_rsp_class
);
  localparam int NB = 1 << HW;
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;
  localparam logic [PW-1:0] NIL = '1;
  localparam logic [31:0] EMPTY = {1'b0, {(31-PW){1'b0}}, NIL};

  typedef enum logic [3:0] {S_SWEEP, S_IDLE, S_LOCK, S_WALK, S_CLS,
                            S_ULHD, S_ULWK, S_INS, S_RESP} st_t;

  function automatic logic [15:0] crc16(input logic [103:0] d);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int i = 103; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  logic [31:0]    bkt   [NB];
  logic [103:0]   e_key [NENT];
  logic [7:0]     e_cls [NENT];
  logic [PW-1:0]  e_nxt [NENT];
  logic [HW-1:0]  e_bkt [NENT];

  st_t           st;
  logic [103:0]  key_q;
  logic [HW-1:0] bix, sweep;
  logic [PW-1:0] cur;
  logic [7:0]    cls_q;
  logic          hit_q, fpend;
  logic [IW-1:0] wp;
  logic [IW:0]   cnt;

  wire [15:0]    req_crc = crc16(req_key);
  wire [IW-1:0]  cur_ix  = cur[IW-1:0];
  wire [PW-1:0]  head    = bkt[bix][PW-1:0];
  wire [HW-1:0]  vb      = e_bkt[wp];
  wire [PW-1:0]  vptr    = PW'(wp);
  wire           full    = (cnt == (IW+1)'(NENT));

  assign req_ready     = (st == S_IDLE) && !flush && !fpend;
  assign rsp_valid     = (st == S_RESP);
  assign rsp_hit       = hit_q;
  assign rsp_class     = cls_q;
  assign cls_req_valid = (st == S_CLS);
  assign cls_req_key   = key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SWEEP; sweep <= '0; fpend <= 1'b0; wp <= '0; cnt <= '0;
      key_q <= '0; bix <= '0; cur <= NIL; cls_q <= '0; hit_q <= 1'b0;
    end else begin
      if (flush) fpend <= 1'b1;
      case (st)
        S_SWEEP: begin
          bkt[sweep] <= EMPTY;
          sweep <= sweep + 1'b1;
          if (sweep == HW'(NB-1)) begin
            st <= S_IDLE; wp <= '0; cnt <= '0;
          end
        end
        S_IDLE: begin
          if (flush || fpend) begin
            st <= S_SWEEP; sweep <= '0; fpend <= 1'b0;
          end else if (req_valid) begin
            key_q <= req_key; bix <= req_crc[HW-1:0]; st <= S_LOCK;
          end
        end
        S_LOCK: if (!bkt[bix][31]) begin
          bkt[bix][31] <= 1'b1; cur <= head; st <= S_WALK;
        end
        S_WALK: begin
          if (cur == NIL) st <= S_CLS;
          else if (e_key[cur_ix] == key_q) begin
            cls_q <= e_cls[cur_ix]; hit_q <= 1'b1;
            bkt[bix][31] <= 1'b0; st <= S_RESP;
          end else cur <= e_nxt[cur_ix];
        end
        S_CLS: if (cls_rsp_valid) begin
          cls_q <= cls_rsp_class; hit_q <= 1'b0;
          st <= full ? S_ULHD : S_INS;
        end
        S_ULHD: begin
          if (bkt[vb][PW-1:0] == vptr) begin
            bkt[vb][PW-1:0] <= NIL; st <= S_INS;
          end else begin
            cur <= bkt[vb][PW-1:0]; st <= S_ULWK;
          end
        end
        S_ULWK: begin
          if (e_nxt[cur_ix] == vptr) begin
            e_nxt[cur_ix] <= NIL; st <= S_INS;
          end else cur <= e_nxt[cur_ix];
        end
        S_INS: begin
          e_key[wp] <= key_q; e_cls[wp] <= cls_q;
          e_bkt[wp] <= bix;   e_nxt[wp] <= head;
          bkt[bix]  <= {1'b0, {(31-PW){1'b0}}, vptr};
          wp <= (wp == IW'(NENT-1)) ? '0 : wp + 1'b1;
          if (!full) cnt <= cnt + 1'b1;
          st <= S_RESP;
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flow_cache_chk.sv
module flow_cache_chk #(
  parameter int NENT = 256,
  parameter int CW   = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          cls_req_valid,
  input logic          cls_rsp_valid,
  input logic [103:0]  cls_req_key,
  input logic [CW-1:0] cnt
);
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r4_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (rsp_valid || cls_req_valid)));
  a_r3_cls_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_req_valid && !cls_rsp_valid) |=> (cls_req_valid && $stable(cls_req_key)));
  a_r3_cls_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_req_valid && cls_rsp_valid) |=> !cls_req_valid);
  a_r7_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);
  a_r5_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NENT));
endmodule

bind flow_cache flow_cache_chk #(.NENT(NENT), .CW(IW+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .cls_req_valid(cls_req_valid),
  .cls_rsp_valid(cls_rsp_valid), .cls_req_key(cls_req_key), .cnt(cnt));

// File: tb/flow_cache_bench.sv
`timescale 1ns/1ps
module flow_cache_bench;
  localparam int HW = 3;
  localparam int NENT = 16;
  localparam int NB = 1 << HW;

  logic clk = 0, rst_n = 0, flush = 0, req_valid = 0, cls_rsp_valid = 0;
  logic [103:0] req_key = '0;
  logic [7:0] cls_rsp_class = '0;
  logic req_ready, rsp_valid, rsp_hit, cls_req_valid;
  logic [7:0] rsp_class;
  logic [103:0] cls_req_key;
  int checks = 0, errors = 0;
  logic [103:0] mq[$];

  always #5 clk = ~clk;

  flow_cache #(.HW(HW), .NENT(NENT)) u_flow_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_key(req_key), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_class(rsp_class), .cls_req_valid(cls_req_valid),
    .cls_req_key(cls_req_key), .cls_rsp_valid(cls_rsp_valid),
    .cls_rsp_class(cls_rsp_class));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bucket_of(input logic [103:0] k);
    logic [15:0] r = 16'hFFFF;
    for (int b = 103; b >= 0; b--)
      r = (r[15] ^ k[b]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return int'(r) % NB;
  endfunction

  function automatic logic [103:0] mk(input int i);
    return {32'h0A00_0100 + i, 32'hC0A8_0000 ^ (i * 7), 16'd80 + 16'(i), 16'd4000, 8'd6};
  endfunction

  function automatic logic [7:0] cls_of(input logic [103:0] k);
    return k[7:0] ^ k[39:32] ^ k[71:64] ^ 8'h5A;
  endfunction

  task automatic lookup(input logic [103:0] k, input int dly, input int fl_at);
    int pos = -1, newer = 0, n = 1, dc = 0, g = 0;
    bit saw = 0;
    for (int i = 0; i < mq.size(); i++) if (mq[i] == k) pos = i;
    if (pos >= 0)
      for (int j = pos + 1; j < mq.size(); j++)
        if (bucket_of(mq[j]) == bucket_of(k)) newer++;
    while (!req_ready && g < 100) begin @(negedge clk); g++; end
    req_valid = 1; req_key = k;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && n < 400) begin
      if (req_ready) chk(0, "R4 ready while busy", 1, 0);
      flush = (n == fl_at);
      if (cls_rsp_valid) cls_rsp_valid = 0;
      else if (cls_req_valid) begin
        if (!saw) chk(cls_req_key == k, "R3 classifier key", longint'(cls_req_key[63:0]), longint'(k[63:0]));
        saw = 1;
        if (dc == dly) begin cls_rsp_valid = 1; cls_rsp_class = cls_of(k); end
        else dc++;
      end
      @(negedge clk); n++;
    end
    flush = 0;
    chk(rsp_valid, "R4 response arrives", rsp_valid, 1);
    chk(rsp_hit == (pos >= 0), pos >= 0 ? "R2 hit flag" : "R3 miss flag", rsp_hit, pos >= 0);
    chk(rsp_class == cls_of(k), "R2 R3 class", rsp_class, cls_of(k));
    chk(saw == (pos < 0), "R3 classifier used only on miss", saw, pos < 0);
    if (pos >= 0) chk(n == 3 + newer, "R2 R1 hit latency", n, 3 + newer);
    @(negedge clk);
    chk(!rsp_valid, "R4 single-cycle response", rsp_valid, 0);
    if (pos < 0) begin
      if (mq.size() == NENT) void'(mq.pop_front());
      mq.push_back(k);
    end
  endtask

  task automatic count_low(input int exp, input string tag);
    int n = 0;
    while (!req_ready && n < 100) begin n++; @(negedge clk); end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic do_flush(input bit with_req, input logic [103:0] k);
    flush = 1; req_valid = with_req; req_key = k;
    #1 chk(!req_ready, "R7 flush masks ready", req_ready, 0);
    @(negedge clk);
    flush = 0; req_valid = 0;
    count_low(NB, "R6 flush sweep length");
    mq.delete();
    chk(!rsp_valid, "R7 no response to masked request", rsp_valid, 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [103:0] sb[$];
    @(negedge clk); @(negedge clk);
    chk(!req_ready && !rsp_valid && !cls_req_valid, "R8 reset outputs", req_ready, 0);
    rst_n = 1;
    count_low(NB, "R8 post-reset sweep length");
    for (int i = 0; i < 300 && sb.size() < 3; i++)
      if (bucket_of(mk(i)) == 2) sb.push_back(mk(i));
    for (int i = 0; i < 3; i++) lookup(sb[i], i, -1);
    for (int i = 0; i < 3; i++) lookup(sb[i], 0, -1);
    lookup(mk(500), 2, -1);
    lookup(mk(500), 0, -1);
    // R5: overfill the pool and check FIFO replacement
    for (int i = 100; i < 124; i++) lookup(mk(i), i % 3, -1);
    lookup(mk(123), 0, -1);
    lookup(mk(100), 1, -1);
    lookup(mk(110), 0, -1);
    lookup(sb[0], 0, -1);
    for (int i = 105; i < 124; i++) lookup(mk(i), 0, -1);
    // R6: plain flush empties the cache
    do_flush(0, '0);
    lookup(mk(110), 0, -1);
    lookup(mk(110), 0, -1);
    // R7: flush and request in the same cycle
    do_flush(1, mk(700));
    lookup(mk(700), 1, -1);
    // R7: flush arriving during a miss is deferred
    lookup(mk(800), 5, 3);
    count_low(NB + 1, "R7 deferred flush length");
    mq.delete();
    lookup(mk(800), 0, -1);
    lookup(mk(700), 0, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule